// File: doc/BRIEF.md
# Watchdog Timer with Write-Once Configuration and Reset-Cause Register

This block guards a system against runaway software. A free-running counter, clocked at four times the bus rate, measures the time since software last serviced it. If that time reaches the selected timeout, the block drives a system reset request for a fixed number of cycles and then starts counting again. Software services the watchdog by writing any value to a dedicated service address.

A configuration byte sets the timeout length and can turn the watchdog off. Only the first write after any reset is accepted. Later writes are dropped until the next reset, which clears the byte and opens it again. A reset-cause byte records what caused the last reset. The sources are power-on, the external reset pin, the watchdog itself, an illegal opcode, an illegal address, monitor-mode entry and low voltage. Reading the byte clears it. Power-on reset loads a value of its own. The other sources arrive as one-cycle request pulses and start the same reset sequence as a watchdog expiry.

Accesses use a small register port with separate write and read strobes and a 2-bit address: 0 is the configuration byte, 1 is the reset-cause byte, 2 is the service address, and 3 is unused. The asynchronous active-low power-on reset is released synchronously inside the block.

Top module: `wdt_guard`

## Requirements
- R1: After power-on reset the reset-cause byte reads 0x80 (bit 7 only), the configuration byte reads 0x00 and the reset output is low.
- R2: With configuration bit 7 at 0, the reset output rises exactly LONG_CYC clock edges after the edge that accepted the last service write (default 2^18-2^4). With bit 7 at 1 it rises after SHORT_CYC edges (default 2^13-2^4). The service write is a write to address 2.
- R3: Service writes spaced exactly one timeout apart keep the reset output low indefinitely.
- R4: The reset output stays high for exactly RST_HOLD cycles. Without service, the next expiry comes a full timeout after the edge where the output falls.
- R5: With configuration bit 0 at 1 the watchdog never raises the reset output, however long service is withheld.
- R6: Only the first configuration write after a reset is stored. Later writes leave the byte unchanged, and the byte reads back its stored value at any time.
- R7: Every reset started by this block clears the configuration byte to 0x00 and accepts a new first write afterwards.
- R8: A reset other than power-on loads the reset-cause byte with the flags of every source requesting in that cycle and clears the other flags. The flag positions are: pin bit 6, watchdog bit 5, illegal opcode bit 4, illegal address bit 3, monitor entry bit 2, low voltage bit 1. Bit 0 always reads 0.
- R9: A read of address 1 returns the reset-cause byte and clears it to 0x00 from the next cycle on.
- R10: While the reset output is high, new reset requests and bus writes and clears are ignored, and the hold length does not change.
- R11: A one-cycle reset request pulse raises the reset output at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, four times the bus rate |
| arst_n | input | 1 | Asynchronous active-low power-on reset |
| acc_wr | input | 1 | Write strobe for the register port |
| acc_rd | input | 1 | Read strobe for the register port |
| acc_addr | input | 2 | Register select: 0 config, 1 reset cause, 2 service |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the selected register |
| req_pin | input | 1 | External reset pin request pulse |
| req_badop | input | 1 | Illegal-opcode reset request pulse |
| req_badaddr | input | 1 | Illegal-address reset request pulse |
| req_monitor | input | 1 | Monitor-mode entry reset request pulse |
| req_lowv | input | 1 | Low-voltage reset request pulse |
| sys_rst_out | output | 1 | System reset request driven by the block |

## Verification
The timeout is measured in exact edge counts in four situations: from a service write under each rate setting, from the falling edge of a hold, and with service writes spaced exactly one timeout apart. These separate an off-by-one in the compare, a restart on the wrong event, and a wrong selection of the limit. The reset sources are tried as a single pin pulse, as two simultaneous requests, and as a request that lands inside an active hold. These show whether the cause byte is loaded as a set or in priority order, and whether hold-time requests leak through. Configuration writes are tried before and after the lock, while the watchdog is off, and during a hold, to show that the lock, the clear on reset and the gating during the hold are all in place.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int SRC_N  = 6;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CFG   = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_KICK  = 2'd2,
    SEL_NONE  = 2'd3
  } sel_e;

  // configuration byte fields
  localparam int CFG_RATE_BIT = 7;  // 1 = short timeout
  localparam int CFG_OFF_BIT  = 0;  // 1 = watchdog off

  // reset-cause byte value after power-on
  localparam logic [DATA_W-1:0] CAUSE_POWER_VAL = 8'h80;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         wipe,
  output logic [W-1:0] cfg_q,
  output logic         locked_q
);
  logic         en;
  logic [W-1:0] cfg_d;
  logic         lock_d;

  always_comb begin
    en     = wipe || (wr_en && !locked_q);
    cfg_d  = wipe ? '0 : wdata;
    lock_d = !wipe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else if (en) begin
      cfg_q    <= cfg_d;
      locked_q <= lock_d;
    end
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int SHORT_CYC = 8176,
  parameter int LONG_CYC  = 262128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_short,
  input  logic halt,
  input  logic kick,
  input  logic wipe,
  output logic expire
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d, last;
  logic          clr;

  always_comb begin
    last   = rate_short ? SHORT_LAST : LONG_LAST;
    // compare with >= so a switch to the short limit after the count
    // has already passed it still expires at once
    expire = !halt && !kick && (cnt_q >= last);
    clr    = halt || kick || wipe || expire;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause
  import wdt_pkg::*;
#(
  parameter int N = SRC_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      flags,
  input  logic              load,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] cause_q
);
  logic              en;
  logic [DATA_W-1:0] cause_d;

  always_comb begin
    en      = load || rd_clr;
    cause_d = '0;
    // flags occupy bits N..1, bit 0 stays zero; a new load wins over a clear
    if (load) cause_d[N:1] = flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cause_q <= CAUSE_POWER_VAL;
    else if (en) cause_q <= cause_d;
  end
endmodule

// File: rtl/wdt_hold.sv
module wdt_hold #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0] left_q, left_d;
  logic          en;

  always_comb begin
    en     = start || (left_q != '0);
    left_d = start ? HW'(HOLD) : left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  left_q <= '0;
    else if (en) left_q <= left_d;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int SHORT_CYC   = 8176,
  parameter int LONG_CYC    = 262128,
  parameter int RST_HOLD    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              req_pin,
  input  logic              req_badop,
  input  logic              req_badaddr,
  input  logic              req_monitor,
  input  logic              req_lowv,
  output logic              sys_rst_out
);
  logic              srst_n;
  logic              in_hold;
  logic              bus_live;
  sel_e              sel;
  logic              kick, cfg_we, cause_rd;
  logic              wdog_fire;
  logic              ext_any;
  logic              trig;
  logic [SRC_N-1:0]  src_vec;
  logic [DATA_W-1:0] cfg_q;
  logic              cfg_locked;
  logic [DATA_W-1:0] cause_q;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .srst_n (srst_n)
  );

  // bus decode, everything gated off while the reset output is high
  always_comb begin
    sel      = sel_e'(acc_addr);
    bus_live = !in_hold;
    kick     = acc_wr && (sel == SEL_KICK)  && bus_live;
    cfg_we   = acc_wr && (sel == SEL_CFG)   && bus_live;
    cause_rd = acc_rd && (sel == SEL_CAUSE) && bus_live;
  end

  // source order gives the cause bit order: pin, watchdog, opcode, address, monitor, low voltage
  always_comb begin
    ext_any = bus_live && (req_pin || req_badop || req_badaddr || req_monitor || req_lowv);
    src_vec = {req_pin, wdog_fire, req_badop, req_badaddr, req_monitor, req_lowv}
              & {SRC_N{bus_live}};
    trig    = |src_vec;
  end

  wdt_cfg_reg #(.W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (cfg_we),
    .wdata    (acc_wdata),
    .wipe     (trig),
    .cfg_q    (cfg_q),
    .locked_q (cfg_locked)
  );

  wdt_count #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_count (
    .clk        (clk),
    .rst_n      (srst_n),
    .rate_short (cfg_q[CFG_RATE_BIT]),
    .halt       (cfg_q[CFG_OFF_BIT] || in_hold),
    .kick       (kick),
    .wipe       (ext_any),
    .expire     (wdog_fire)
  );

  wdt_cause #(.N(SRC_N)) u_cause (
    .clk     (clk),
    .rst_n   (srst_n),
    .flags   (src_vec),
    .load    (trig),
    .rd_clr  (cause_rd),
    .cause_q (cause_q)
  );

  wdt_hold #(.HOLD(RST_HOLD)) u_hold (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (trig),
    .active (in_hold)
  );

  assign sys_rst_out = in_hold;

  always_comb begin
    case (sel)
      SEL_CFG:   acc_rdata = cfg_q;
      SEL_CAUSE: acc_rdata = cause_q;
      default:   acc_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int HOLD = 4
) (
  input logic       clk,
  input logic       srst_n,
  input logic       sys_rst_out,
  input logic       acc_rd,
  input logic [1:0] acc_addr,
  input logic       ext_any,
  input logic       trig,
  input logic       cfg_locked,
  input logic [7:0] cfg_q,
  input logic [7:0] cause_q
);
  localparam int LW = $clog2(HOLD + 2);
  logic [LW-1:0] hi_len;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)          hi_len <= '0;
    else if (sys_rst_out) hi_len <= hi_len + 1'b1;
    else                  hi_len <= '0;
  end

  a_r4_hold_len: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(sys_rst_out) |-> (hi_len == LW'(HOLD)));

  a_r11_req_starts_reset: assert property (@(posedge clk) disable iff (!srst_n)
    ext_any |=> sys_rst_out);

  a_r5_off_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_q[0] && !ext_any && !sys_rst_out) |=> !sys_rst_out);

  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_locked && !trig) |=> $stable(cfg_q));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!srst_n)
    (acc_rd && acc_addr == 2'd1 && !sys_rst_out && !trig) |=> (cause_q == 8'h00));

  a_r8_low_bit_zero: assert property (@(posedge clk) disable iff (!srst_n)
    !cause_q[0]);
endmodule

bind wdt_guard wdt_guard_chk #(.HOLD(RST_HOLD)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .sys_rst_out (sys_rst_out),
  .acc_rd      (acc_rd),
  .acc_addr    (acc_addr),
  .ext_any     (ext_any),
  .trig        (trig),
  .cfg_locked  (cfg_locked),
  .cfg_q       (cfg_q),
  .cause_q     (cause_q)
);

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
  localparam int SHORT = 48;
  localparam int LONG  = 240;
  localparam int HOLD  = 4;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       acc_wr = 1'b0, acc_rd = 1'b0;
  logic [1:0] acc_addr = 2'd3;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic       req_pin = 1'b0, req_badop = 1'b0, req_badaddr = 1'b0;
  logic       req_monitor = 1'b0, req_lowv = 1'b0;
  logic       sys_rst_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  wdt_guard #(.SHORT_CYC(SHORT), .LONG_CYC(LONG), .RST_HOLD(HOLD)) dut (
    .clk(clk), .arst_n(arst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .req_pin(req_pin), .req_badop(req_badop), .req_badaddr(req_badaddr),
    .req_monitor(req_monitor), .req_lowv(req_lowv), .sys_rst_out(sys_rst_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0; acc_addr = 2'd3;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    acc_rd = 1'b0; acc_addr = 2'd3;
  endtask

  task automatic count_until_rise(output int k);
    k = 0;
    while (k < 2000) begin
      @(negedge clk);
      k++;
      if (sys_rst_out) break;
    end
  endtask

  // called at a negedge where the output is already high
  task automatic count_high(output int h);
    h = 1;
    while (h < 100) begin
      @(negedge clk);
      if (!sys_rst_out) break;
      h++;
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    #2;
    if (acc_rd) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(acc_rdata), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k, h, seen;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset output low after power-on", int'(sys_rst_out), 0);
    bus_read(2'd1, 8'h80, "R1 cause after power-on");
    bus_read(2'd1, 8'h00, "R9 cause cleared by read");
    bus_read(2'd0, 8'h00, "R1 config after power-on");

    // R2 long timeout, R4 hold length and restart from falling edge
    bus_write(2'd2, 8'h5a);
    count_until_rise(k);
    chk("R2 long timeout edges", k, LONG);
    count_high(h);
    chk("R4 hold length", h, HOLD);
    count_until_rise(k);
    chk("R4 timeout from hold fall", k, LONG);
    count_high(h);
    bus_read(2'd1, 8'h20, "R8 watchdog flag bit 5");
    bus_read(2'd1, 8'h00, "R9 cleared after watchdog flag read");
    bus_read(2'd0, 8'h00, "R7 config cleared by watchdog reset");

    // R6 write-once, R2 short timeout
    bus_write(2'd0, 8'h80);
    bus_write(2'd0, 8'h01);
    bus_read(2'd0, 8'h80, "R6 second config write ignored");
    bus_write(2'd2, 8'h00);
    count_until_rise(k);
    chk("R2 short timeout edges", k, SHORT);
    count_high(h);
    chk("R4 hold length short mode", h, HOLD);
    bus_read(2'd0, 8'h00, "R7 config cleared again");

    // R3 service exactly one timeout apart
    bus_write(2'd0, 8'h80);
    bus_write(2'd2, 8'h00);
    seen = 0;
    for (int p = 0; p < 5; p++) begin
      repeat (SHORT - 2) begin
        @(negedge clk);
        if (sys_rst_out) seen = 1;
      end
      bus_write(2'd2, 8'h00);
      if (sys_rst_out) seen = 1;
    end
    chk("R3 on-time service keeps reset low", seen, 0);
    count_until_rise(k);
    chk("R2 short timeout after last service", k, SHORT);
    count_high(h);

    // R5 watchdog off
    bus_write(2'd0, 8'h01);
    seen = 0;
    repeat (3 * LONG) begin
      @(negedge clk);
      if (sys_rst_out) seen = 1;
    end
    chk("R5 no reset while off", seen, 0);
    bus_write(2'd0, 8'h80);
    bus_read(2'd0, 8'h01, "R6 lock holds off setting");
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (sys_rst_out) seen = 1;
    end
    chk("R5 still off after ignored write", seen, 0);

    // R11 pin pulse, R7 lock re-opens
    @(negedge clk); req_pin = 1'b1;
    @(negedge clk); req_pin = 1'b0;
    chk("R11 reset rises edge after pulse", int'(sys_rst_out), 1);
    count_high(h);
    chk("R4 hold length after pin", h, HOLD);
    bus_read(2'd1, 8'h40, "R8 pin flag bit 6");
    bus_read(2'd0, 8'h00, "R7 config cleared by pin reset");
    bus_write(2'd0, 8'h80);
    bus_read(2'd0, 8'h80, "R7 first write accepted after reset");

    // R8 two sources in one cycle
    @(negedge clk); req_badop = 1'b1; req_lowv = 1'b1;
    @(negedge clk); req_badop = 1'b0; req_lowv = 1'b0;
    count_high(h);
    bus_read(2'd1, 8'h12, "R8 opcode and low-voltage flags");

    // R10 requests and writes during hold ignored
    @(negedge clk); req_badaddr = 1'b1;
    @(negedge clk); req_badaddr = 1'b0;
    req_monitor = 1'b1; acc_wr = 1'b1; acc_addr = 2'd0; acc_wdata = 8'h01;
    @(negedge clk); req_monitor = 1'b0; acc_wr = 1'b0; acc_addr = 2'd3;
    h = 2;
    while (sys_rst_out && h < 100) begin
      @(negedge clk);
      if (sys_rst_out) h++;
    end
    chk("R10 hold not extended by request", h, HOLD);
    bus_read(2'd1, 8'h08, "R10 only address flag recorded");
    bus_read(2'd0, 8'h00, "R10 config write during hold dropped");

    // R1 power-on reset mid-run
    @(negedge clk); arst_n = 1'b0;
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset output low after second power-on", int'(sys_rst_out), 0);
    bus_read(2'd1, 8'h80, "R1 cause after second power-on");
    bus_read(2'd0, 8'h00, "R1 config after second power-on");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule